// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It covers a small integer subset: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch when two registers are equal, and an absolute jump. The core contains its own instruction memory, its own data memory and a 32-entry register file. A main decoder sorts each opcode into a class. A second decoder level turns that class, together with the function field, into an ALU operation. The next program counter is chosen from three sources: the sequential address, the branch target or the jump address.

Both memories are small word arrays that are filled through a load port. This is normally done while reset is held. Because the core has no other visible state, it also drives out the program counter, the register write that is about to commit and the data memory store that is about to commit. The write and store outputs are combinational views of the current instruction, so each instruction's effect can be seen in the cycle before it commits.

There is no multi-step control. The run is a single implicit state: the core holds PC at zero while reset is high and otherwise advances one instruction per edge. The only transitions are from reset into run (reset released) and from any cycle back to reset (reset raised).

Top module: `sc_cpu_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0. While reset is high, no register write and no store is reported or committed.
- R2: When an instruction is not a taken branch and not a jump, the next program counter is the current one plus 4.
- R3: Load (opcode 35) computes the address as rs plus the 16-bit offset in bits [15:0], sign-extended. It writes the memory word at that address into rt. The memory word index is address bits [MEM_AW+1:2].
- R4: Store (opcode 43) forms its address the same way as R3. It writes register rt to the data memory and writes no register.
- R5: Register-type instructions (opcode 0) select their operation from function bits [5:0]: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than. The result is written to rd, which is bits [15:11]. The sources are rs, bits [25:21], and rt, bits [20:16].
- R6: Set-less-than compares its operands as signed numbers and writes 1 or 0.
- R7: Branch-equal (opcode 4) is taken when rs minus rt is zero. The target is PC+4 plus the sign-extended displacement shifted left by two. A branch that is not taken falls through to PC+4.
- R8: Jump (opcode 2) sets the PC to the old PC bits [31:28], followed by the 26-bit field in bits [25:0], followed by two zero bits.
- R9: Register 0 always reads as zero. A write that names it is dropped and is not reported on the write outputs.
- R10: An unrecognised opcode acts as a no-op: no register write, no store, and the PC advances by 4.
- R11: A register-type instruction with an unrecognised function code writes no register and advances the PC by 4.
- R12: When the load port is enabled, it writes ld_data into the word at ld_addr. It targets the data memory when ld_dmem is 1 and the instruction memory when ld_dmem is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load-port write enable |
| ld_dmem | input | 1 | Load-port target: 1 data memory, 0 instruction memory |
| ld_addr | input | MEM_AW | Load-port word index |
| ld_data | input | 32 | Load-port word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write commits at the next edge |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | Store commits at the next edge |
| dm_addr_o | output | 32 | Byte address of the store or load |
| dm_wdata_o | output | 32 | Word being stored |

## Verification
A wrong decode or a wrong ALU selection shows up in the same cycle on the write and store outputs, because they are combinational from the current instruction. A corrupted register value stays hidden until a later instruction reads that register, so the programs make every result flow into a later store or compare. A wrong next-PC choice appears on pc_o one edge later, and the wrong path then changes every following write. For that reason the comparison is made on every cycle, not only at the end of the program.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_JMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ  = 6'd4;
    localparam logic [5:0] OPC_LOAD = 6'd35;
    localparam logic [5:0] OPC_STOR = 6'd43;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_MEM = 2'b00,
        CLS_CMP = 2'b01,
        CLS_REG = 2'b10
    } op_class_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_sel_e;

    typedef struct packed {
        logic      known;
        logic      reg_write;
        logic      dst_is_rd;
        logic      b_is_imm;
        logic      mem_write;
        logic      wb_from_mem;
        logic      is_branch;
        logic      is_jump;
        op_class_e cls;
    } ctrl_t;
endpackage

// File: rtl/sc_word_mem.sv
module sc_word_mem #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_b
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // a committed write is visible to the next instruction that reads it
    assert_write_visible_R5: assert property (@(posedge clk) disable iff (rst)
        (we && (wa != '0)) |=> ((ra_a != $past(wa)) || (rd_a == $past(wd))));
endmodule

// File: rtl/sc_decode.sv
module sc_decode
    import cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_sel_e   alu_sel,
    output logic       funct_ok
);
    // level one: opcode to control word and operation class
    always_comb begin
        ctrl = '0;
        ctrl.cls = CLS_MEM;
        unique case (opcode)
            OPC_REG: begin
                ctrl.known     = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.cls       = CLS_REG;
            end
            OPC_LOAD: begin
                ctrl.known       = 1'b1;
                ctrl.reg_write   = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.cls         = CLS_MEM;
            end
            OPC_STOR: begin
                ctrl.known     = 1'b1;
                ctrl.b_is_imm  = 1'b1;
                ctrl.mem_write = 1'b1;
                ctrl.cls       = CLS_MEM;
            end
            OPC_BEQ: begin
                ctrl.known     = 1'b1;
                ctrl.is_branch = 1'b1;
                ctrl.cls       = CLS_CMP;
            end
            OPC_JMP: begin
                ctrl.known   = 1'b1;
                ctrl.is_jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

    // level two: class plus function field to ALU operation
    always_comb begin
        alu_sel  = ALU_ADD;
        funct_ok = 1'b1;
        unique case (ctrl.cls)
            CLS_MEM: alu_sel = ALU_ADD;
            CLS_CMP: alu_sel = ALU_SUB;
            CLS_REG: begin
                unique case (funct)
                    FN_ADD:  alu_sel = ALU_ADD;
                    FN_SUB:  alu_sel = ALU_SUB;
                    FN_AND:  alu_sel = ALU_AND;
                    FN_OR:   alu_sel = ALU_OR;
                    FN_SLT:  alu_sel = ALU_SLT;
                    default: funct_ok = 1'b0;
                endcase
            end
            default: funct_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import cpu_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_sel_e      sel,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          zero
);
    always_comb begin
        unique case (sel)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
    import cpu_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_dmem,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    output logic [31:0]       pc_o,
    output logic              rf_we_o,
    output logic [4:0]        rf_waddr_o,
    output logic [31:0]       rf_wdata_o,
    output logic              dm_we_o,
    output logic [31:0]       dm_addr_o,
    output logic [31:0]       dm_wdata_o
);
    localparam int IDX_HI = MEM_AW + 1;

    logic [XLEN-1:0] pc_q, pc_next, pc_seq, pc_br, pc_jmp;
    logic [XLEN-1:0] instr, imm_ext, opnd_a, opnd_b, rs_val, rt_val;
    logic [XLEN-1:0] alu_y, dm_rdata, wb_val;
    logic [RIDX_W-1:0] dst_idx;
    ctrl_t    ctrl;
    alu_sel_e alu_sel;
    logic     funct_ok, alu_zero, take_br;
    logic     im_we, dm_we_any;
    logic [MEM_AW-1:0] dm_widx;
    logic [XLEN-1:0]   dm_wval;

    // program counter register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    // next-PC selection: sequential, branch, jump
    assign pc_seq  = pc_q + XLEN'(4);
    assign pc_br   = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
    assign pc_jmp  = {pc_q[31:28], instr[25:0], 2'b00};
    assign take_br = ctrl.is_branch && alu_zero;

    always_comb begin
        if (ctrl.is_jump) begin
            pc_next = pc_jmp;
        end else if (take_br) begin
            pc_next = pc_br;
        end else begin
            pc_next = pc_seq;
        end
    end

    // instruction memory, filled only through the load port
    assign im_we = ld_en && !ld_dmem;

    sc_word_mem #(.AW(MEM_AW), .DW(XLEN)) imem_i (
        .clk   (clk),
        .we    (im_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (pc_q[IDX_HI:2]),
        .rdata (instr)
    );

    sc_decode dec_i (
        .opcode   (instr[31:26]),
        .funct    (instr[5:0]),
        .ctrl     (ctrl),
        .alu_sel  (alu_sel),
        .funct_ok (funct_ok)
    );

    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign dst_idx = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];

    sc_regfile #(.AW(RIDX_W), .DW(XLEN)) rf_i (
        .clk  (clk),
        .rst  (rst),
        .we   (rf_we_o),
        .wa   (dst_idx),
        .wd   (wb_val),
        .ra_a (instr[25:21]),
        .rd_a (rs_val),
        .ra_b (instr[20:16]),
        .rd_b (rt_val)
    );

    assign opnd_a = rs_val;
    assign opnd_b = ctrl.b_is_imm ? imm_ext : rt_val;

    sc_alu #(.DW(XLEN)) alu_i (
        .sel  (alu_sel),
        .a    (opnd_a),
        .b    (opnd_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: the load port has priority over a store
    assign dm_we_o   = ctrl.mem_write && !rst;
    assign dm_we_any = (ld_en && ld_dmem) || dm_we_o;
    assign dm_widx   = (ld_en && ld_dmem) ? ld_addr : alu_y[IDX_HI:2];
    assign dm_wval   = (ld_en && ld_dmem) ? ld_data : rt_val;

    sc_word_mem #(.AW(MEM_AW), .DW(XLEN)) dmem_i (
        .clk   (clk),
        .we    (dm_we_any),
        .waddr (dm_widx),
        .wdata (dm_wval),
        .raddr (alu_y[IDX_HI:2]),
        .rdata (dm_rdata)
    );

    assign wb_val = ctrl.wb_from_mem ? dm_rdata : alu_y;

    assign pc_o       = pc_q;
    assign rf_we_o    = ctrl.reg_write && funct_ok && !rst && (dst_idx != '0);
    assign rf_waddr_o = dst_idx;
    assign rf_wdata_o = wb_val;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    assert_pc_zero_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == '0));

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.is_jump && !take_br) |=> (pc_q == $past(pc_q) + XLEN'(4)));

    assert_store_no_regwrite_R4: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o);

    assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
        take_br |=> (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}));

    assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl.is_jump |=> (pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00}));

    assert_unknown_op_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !ctrl.known |-> (!rf_we_o && !dm_we_o));
endmodule

// File: tb/sc_cpu_core_tb.sv
`timescale 1ns/1ps
module sc_cpu_core_tb_top;
    localparam int AW    = 6;
    localparam int NCYC  = 30;

    typedef struct {
        logic [31:0] pc;
        logic        rf_we;
        logic [4:0]  rf_wa;
        logic [31:0] rf_wd;
        logic        dm_we;
        logic [31:0] dm_a;
        logic [31:0] dm_wd;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_en = 1'b0, ld_dmem = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    int checks = 0;
    int failures = 0;
    logic mon_active = 1'b0;
    exp_t exp_q[$];

    logic [31:0] m_im [1<<AW];
    logic [31:0] m_dm [1<<AW];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;

    always #2.5 clk = ~clk;

    sc_cpu_core #(.MEM_AW(AW)) dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    // reference model step: builds the expected item for the current PC
    task automatic model_step(output exp_t e);
        logic [31:0] ins, a, b, imm, addr, res;
        logic [31:0] nxt;
        ins = m_im[m_pc[AW+1:2]];
        a   = m_rf[ins[25:21]];
        b   = m_rf[ins[20:16]];
        imm = {{16{ins[15]}}, ins[15:0]};
        nxt = m_pc + 4;
        e = '{pc: m_pc, rf_we: 1'b0, rf_wa: '0, rf_wd: '0, dm_we: 1'b0,
              dm_a: '0, dm_wd: '0, tag: "R2"};
        case (ins[31:26])
            6'd0: begin
                e.tag = "R5";
                case (ins[5:0])
                    6'b100000: begin res = a + b; e.rf_we = 1'b1; end
                    6'b100010: begin res = a - b; e.rf_we = 1'b1; end
                    6'b100100: begin res = a & b; e.rf_we = 1'b1; end
                    6'b100101: begin res = a | b; e.rf_we = 1'b1; end
                    6'b101010: begin res = ($signed(a) < $signed(b)) ? 1 : 0;
                                     e.rf_we = 1'b1; e.tag = "R6"; end
                    default:   begin res = '0; e.tag = "R11"; end
                endcase
                if (ins[15:11] == 5'd0 && e.rf_we) begin
                    e.rf_we = 1'b0; e.tag = "R9";
                end
                e.rf_wa = ins[15:11]; e.rf_wd = res;
            end
            6'd35: begin
                addr = a + imm;
                e.tag = "R3"; e.rf_wa = ins[20:16];
                e.rf_wd = m_dm[addr[AW+1:2]];
                e.rf_we = (ins[20:16] != 5'd0);
            end
            6'd43: begin
                addr = a + imm;
                e.tag = (ins[20:16] == 5'd0) ? "R9" : "R4";
                e.dm_we = 1'b1; e.dm_a = addr; e.dm_wd = b;
                m_dm[addr[AW+1:2]] = b;
            end
            6'd4: begin
                e.tag = "R7";
                if (a == b) nxt = m_pc + 4 + {imm[29:0], 2'b00};
            end
            6'd2: begin
                e.tag = "R8";
                nxt = {m_pc[31:28], ins[25:0], 2'b00};
            end
            default: e.tag = "R10";
        endcase
        if (e.rf_we) m_rf[e.rf_wa] = e.rf_wd;
        m_pc = nxt;
    endtask

    // driver: fills the queue with expected items
    task automatic drive_expected(input int n);
        exp_t e;
        for (int i = 0; i < n; i++) begin
            model_step(e);
            exp_q.push_back(e);
        end
    endtask

    task automatic load_word(input logic to_dm, input int idx, input logic [31:0] w);
        @(posedge clk); #1;
        ld_en = 1'b1; ld_dmem = to_dm; ld_addr = AW'(idx); ld_data = w;
        if (to_dm) m_dm[idx] = w; else m_im[idx] = w;
    endtask

    // monitor: pops and compares every cycle while active
    always @(negedge clk) begin
        if (mon_active && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(pc_o == e.pc, e.tag, "pc", pc_o, e.pc);
            chk(rf_we_o == e.rf_we, e.tag, "reg write enable", 32'(rf_we_o), 32'(e.rf_we));
            if (e.rf_we && rf_we_o) begin
                chk(rf_waddr_o == e.rf_wa, e.tag, "reg index", 32'(rf_waddr_o), 32'(e.rf_wa));
                chk(rf_wdata_o == e.rf_wd, e.tag, "reg data", rf_wdata_o, e.rf_wd);
            end
            chk(dm_we_o == e.dm_we, e.tag, "store enable", 32'(dm_we_o), 32'(e.dm_we));
            if (e.dm_we && dm_we_o) begin
                chk(dm_addr_o == e.dm_a, e.tag, "store address", dm_addr_o, e.dm_a);
                chk(dm_wdata_o == e.dm_wd, e.tag, "store data", dm_wdata_o, e.dm_wd);
            end
        end
    end

    initial begin
        #(200000 * 5);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] prog [21];
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < (1 << AW); i++) begin
            m_im[i] = '0;
            m_dm[i] = '0;
        end
        m_pc = '0;
        prog[0]  = enc_i(6'd35, 0, 1, 0);          // R3 load 5
        prog[1]  = enc_i(6'd35, 0, 2, 4);          // R3 load -3
        prog[2]  = enc_r(1, 2, 3, 6'b100000);      // R5 add
        prog[3]  = enc_r(1, 2, 4, 6'b100010);      // R5 sub
        prog[4]  = enc_r(1, 2, 5, 6'b100100);      // R5 and
        prog[5]  = enc_r(1, 2, 6, 6'b100101);      // R5 or
        prog[6]  = enc_r(2, 1, 7, 6'b101010);      // R6 signed less: 1
        prog[7]  = enc_r(1, 2, 8, 6'b101010);      // R6 signed less: 0
        prog[8]  = enc_i(6'd43, 0, 4, 8);          // R4 store
        prog[9]  = enc_r(1, 1, 0, 6'b100000);      // R9 write to r0 dropped
        prog[10] = enc_i(6'd43, 0, 0, 12);         // R9 r0 reads zero
        prog[11] = 32'hFC00_0000;                  // R10 unknown opcode
        prog[12] = enc_r(1, 2, 9, 6'b111111);      // R11 unknown function
        prog[13] = enc_i(6'd4, 1, 2, 5);           // R7 not taken
        prog[14] = enc_i(6'd4, 3, 3, 2);           // R7 taken to 17
        prog[15] = enc_r(1, 1, 9, 6'b100000);      // skipped
        prog[16] = enc_r(1, 1, 9, 6'b100000);      // skipped
        prog[17] = enc_i(6'd35, 4, 10, -4);        // R3 negative offset
        prog[18] = {6'd2, 26'd20};                 // R8 jump
        prog[19] = enc_r(1, 1, 11, 6'b100000);     // skipped
        prog[20] = enc_i(6'd4, 0, 0, -1);          // R7 backward loop

        repeat (2) @(posedge clk);
        for (int i = 0; i < 21; i++) load_word(1'b0, i, prog[i]);   // R12
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'hFFFF_FFFD);
        @(posedge clk); #1;
        ld_en = 1'b0;

        @(negedge clk);
        chk(pc_o == 32'd0, "R1", "pc in reset", pc_o, 32'd0);
        chk(!rf_we_o, "R1", "reg write in reset", 32'(rf_we_o), 32'd0);
        chk(!dm_we_o, "R1", "store in reset", 32'(dm_we_o), 32'd0);

        drive_expected(NCYC);
        @(posedge clk); #1;
        rst = 1'b0;
        mon_active = 1'b1;
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
        mon_active = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(pc_o == 32'd0, "R1", "pc after mid-run reset", pc_o, 32'd0);
        chk(!dm_we_o, "R1", "store after mid-run reset", 32'(dm_we_o), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule